// File: doc/BRIEF.md
# Memory Burst Traffic Generator

This block stands in for a bus master whose only job is to load a memory controller's arbiter. After a start pulse it sends a set number of burst requests over a valid/ready request channel. Each request carries a direction, a start address and a burst length in beats. Completion pulses come back on a separate input. No data moves through the block. It only asks for access, competes in arbitration and lets go when a burst finishes.

Pacing is set in clock cycles. An initial delay comes before the first request. A gap follows each request, drawn from an inclusive `[min, max]` window by a 16-bit LFSR that is seeded on start. An optional pacing mode holds each new request until the previous burst has reported completion. Addresses walk upward from a base in steps of one burst and wrap inside a region. A `done` flag marks the end of the sequence.

The request channel follows the usual valid/ready rules. Once `req_valid` is high it stays high, and the request fields stay unchanged, until `req_ready` is sampled high. The downstream side may hold `req_ready` low for any number of cycles. Holding `req_ready` low only stretches the handshake. It never drops a request and never changes the request's contents.

Top module: `burst_traffic_gen`

## Requirements
- R1: After reset `req_valid` and `done` are low, and no request appears until a start pulse is sampled.
- R2: With first delay D, `req_valid` first rises D+1 cycles after the cycle in which `start` is sampled high (D=0 gives the cycle right after).
- R3: Without completion pacing, the next `req_valid` rises G+1 cycles after the handshake cycle, where G is the drawn gap (G=0 gives back-to-back requests).
- R4: Gap k (k=0,1,...) equals `min + (S_k mod (max-min+1))`. S_0 is the seed (a zero seed is replaced by 1). Each draw then advances the state by S' = {S[14:0], S[15]^S[13]^S[12]^S[10]}. When max < min the gap is min.
- R5: While `req_valid` is high and `req_ready` low, `req_valid` stays high next cycle and `req_addr` and `req_is_read` stay unchanged.
- R6: Exactly the configured total of requests is accepted. A total below 2 is treated as 2.
- R7: `req_is_read` equals the direction captured at start (1 = read, 0 = write). `req_len` equals BURST_BYTES/DATA_BYTES, which is 32 with the defaults 256 and 8.
- R8: `req_addr` = base + offset. The offset starts at 0 and advances by BURST_BYTES after each accepted request. It returns to 0 when the advanced value would reach the region size.
- R9: With completion pacing on, no request is presented after an acceptance until a `burst_done` pulse arrives. The gap then counts from that pulse's cycle under the R3 rule.
- R10: `burst_done` has no effect when completion pacing is off, or when no burst is outstanding.
- R11: `done` rises in the cycle after the final acceptance, or in pacing mode in the cycle after the final completion pulse. It stays high until the next start.
- R12: A start pulse at any time aborts the running sequence, clears `done` and reloads the seed, counters and offset.
- R13: All configuration inputs are captured when start is sampled. Later changes to them have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin or restart the sequence |
| cfg_is_read | input | 1 | Direction of all requests: 1 read, 0 write |
| cfg_total | input | CNT_W | Number of requests to issue |
| cfg_first_dly | input | DLY_W | Cycles before the first request |
| cfg_gap_min | input | DLY_W | Lower gap bound in cycles |
| cfg_gap_max | input | DLY_W | Upper gap bound in cycles |
| cfg_seed | input | 16 | LFSR seed |
| cfg_wait_done | input | 1 | 1 = hold each request until previous completion |
| cfg_base | input | ADDR_W | First address |
| cfg_region | input | ADDR_W | Wrap size of the address walk in bytes |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Arbiter accepts the request |
| req_is_read | output | 1 | Request direction |
| req_addr | output | ADDR_W | Burst start address |
| req_len | output | LEN_W | Burst length in beats |
| burst_done | input | 1 | One-cycle completion pulse |
| done | output | 1 | Sequence finished |

## Verification
The embedded assertions check, on every cycle, the properties that need no scenario. These are: request stability under back-pressure, `done` never overlapping a request, the issue count never passing the total, every drawn gap inside its window, the LFSR never reaching zero, and the address offset staying inside the region. The exact cycle timing of delays and gaps, the seeded gap sequence, wrap points, completion pacing, ignored completion pulses, restart and configuration capture can only be shown by the bench. It runs scenarios against its own cycle model with random back-pressure, and it changes the configuration pins while a sequence is running.

// File: rtl/btg_pkg.sv
package btg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_REQ,
    ST_WAIT,
    ST_GAP,
    ST_FIN
  } btg_state_t;

  localparam int unsigned LFSR_W = 16;
endpackage

// File: rtl/btg_lfsr.sv
module btg_lfsr
  import btg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              step,
  output logic [LFSR_W-1:0] state
);
  logic fb;
  assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk) begin
    if (rst)
      state <= LFSR_W'(1);
    else if (load)
      state <= (seed == '0) ? LFSR_W'(1) : seed;
    else if (step)
      state <= {state[LFSR_W-2:0], fb};
  end

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst) state != '0);
endmodule

// File: rtl/btg_gap_pick.sv
module btg_gap_pick
  import btg_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic [LFSR_W-1:0] rnd,
  input  logic [DLY_W-1:0]  gmin,
  input  logic [DLY_W-1:0]  gmax,
  output logic [DLY_W-1:0]  gap
);
  localparam int unsigned SPAN_W = (DLY_W > LFSR_W ? DLY_W : LFSR_W) + 1;

  logic [SPAN_W-1:0] span_p1;
  logic [SPAN_W-1:0] rem;

  always_comb begin
    if (gmax >= gmin)
      span_p1 = SPAN_W'(gmax - gmin) + SPAN_W'(1);
    else
      span_p1 = SPAN_W'(1);
    rem = SPAN_W'(rnd) % span_p1;
    gap = gmin + DLY_W'(rem);
  end
endmodule

// File: rtl/btg_addr_gen.sv
module btg_addr_gen #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BURST_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] region,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W:0] STRIDE = (ADDR_W+1)'(BURST_BYTES);

  logic [ADDR_W-1:0] base_q, region_q, offset;
  logic [ADDR_W:0]   next_off;

  assign next_off = {1'b0, offset} + STRIDE;
  assign addr     = base_q + offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      region_q <= '0;
      offset   <= '0;
    end else if (load) begin
      base_q   <= base;
      region_q <= region;
      offset   <= '0;
    end else if (step) begin
      if (next_off >= {1'b0, region_q})
        offset <= '0;
      else
        offset <= next_off[ADDR_W-1:0];
    end
  end

  // R8
  offset_range_chk: assert property (@(posedge clk) disable iff (rst)
    (offset == '0) || (offset < region_q));
endmodule

// File: rtl/burst_traffic_gen.sv
module burst_traffic_gen
  import btg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_BYTES  = 8,
  parameter int unsigned BURST_BYTES = 256,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DLY_W       = 16,
  parameter int unsigned BEATS       = BURST_BYTES / DATA_BYTES,
  parameter int unsigned LEN_W       = $clog2(BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_is_read,
  input  logic [CNT_W-1:0]  cfg_total,
  input  logic [DLY_W-1:0]  cfg_first_dly,
  input  logic [DLY_W-1:0]  cfg_gap_min,
  input  logic [DLY_W-1:0]  cfg_gap_max,
  input  logic [15:0]       cfg_seed,
  input  logic              cfg_wait_done,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_region,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_is_read,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  input  logic              burst_done,
  output logic              done
);
  localparam logic [CNT_W-1:0] MIN_TOTAL = CNT_W'(2);

  btg_state_t        state;
  logic [DLY_W-1:0]  timer;
  logic [CNT_W-1:0]  issued, total_q;
  logic [DLY_W-1:0]  gmin_q, gmax_q;
  logic              dir_q, wait_q;

  logic [LFSR_W-1:0] rnd;
  logic [DLY_W-1:0]  gap_val;
  logic              hs, last_hs, gap_load, cmpl, all_issued;

  assign hs         = (state == ST_REQ) && req_ready;
  assign last_hs    = (issued + CNT_W'(1)) == total_q;
  assign all_issued = (issued == total_q);
  assign cmpl       = (state == ST_WAIT) && burst_done;
  assign gap_load   = !start && ((hs && !wait_q && !last_hs) || (cmpl && !all_issued));

  btg_lfsr u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .load  (start),
    .seed  (cfg_seed),
    .step  (gap_load),
    .state (rnd)
  );

  btg_gap_pick #(.DLY_W(DLY_W)) u_gap (
    .rnd  (rnd),
    .gmin (gmin_q),
    .gmax (gmax_q),
    .gap  (gap_val)
  );

  btg_addr_gen #(.ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .load   (start),
    .base   (cfg_base),
    .region (cfg_region),
    .step   (hs && !start),
    .addr   (req_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      timer   <= '0;
      issued  <= '0;
      total_q <= MIN_TOTAL;
      gmin_q  <= '0;
      gmax_q  <= '0;
      dir_q   <= 1'b0;
      wait_q  <= 1'b0;
    end else if (start) begin
      issued  <= '0;
      total_q <= (cfg_total < MIN_TOTAL) ? MIN_TOTAL : cfg_total;
      gmin_q  <= cfg_gap_min;
      gmax_q  <= cfg_gap_max;
      dir_q   <= cfg_is_read;
      wait_q  <= cfg_wait_done;
      if (cfg_first_dly == '0) begin
        state <= ST_REQ;
        timer <= '0;
      end else begin
        state <= ST_DELAY;
        timer <= cfg_first_dly - DLY_W'(1);
      end
    end else begin
      unique case (state)
        ST_IDLE, ST_FIN: ;
        ST_DELAY, ST_GAP: begin
          if (timer == '0) state <= ST_REQ;
          else             timer <= timer - DLY_W'(1);
        end
        ST_REQ: begin
          if (req_ready) begin
            issued <= issued + CNT_W'(1);
            if (wait_q)       state <= ST_WAIT;
            else if (last_hs) state <= ST_FIN;
          end
        end
        ST_WAIT: begin
          if (burst_done && all_issued) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
      if (gap_load) begin
        if (gap_val == '0) begin
          state <= ST_REQ;
        end else begin
          state <= ST_GAP;
          timer <= gap_val - DLY_W'(1);
        end
      end
    end
  end

  assign req_valid   = (state == ST_REQ);
  assign req_is_read = dir_q;
  assign req_len     = LEN_W'(BEATS);
  assign done        = (state == ST_FIN);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !start) |=>
      (req_valid && $stable(req_addr) && $stable(req_is_read)));

  // R11
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid);

  // R6
  issue_bound_chk: assert property (@(posedge clk) disable iff (rst)
    issued <= total_q);

  // R4
  gap_window_chk: assert property (@(posedge clk) disable iff (rst)
    gap_load |-> (gap_val >= gmin_q) && ((gmax_q < gmin_q) || (gap_val <= gmax_q)));

  // R9
  pace_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !burst_done && !start) |=> !req_valid);
endmodule

// File: tb/burst_traffic_gen_bench.sv
module burst_traffic_gen_bench;
  localparam int AW = 32;
  localparam int BB = 256;
  localparam int DB = 8;
  localparam int BIG = 1 << 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cfg_is_read = 1'b0;
  logic [15:0] cfg_total = '0, cfg_first_dly = '0, cfg_gap_min = '0, cfg_gap_max = '0, cfg_seed = '0;
  logic cfg_wait_done = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_region = '0;
  logic req_valid, req_ready = 1'b0, req_is_read;
  logic [AW-1:0] req_addr;
  logic [5:0] req_len;
  logic burst_done = 1'b0;
  logic done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr_m;

  always #10 clk = ~clk;

  burst_traffic_gen u_burst_traffic_gen (
    .clk(clk), .rst(rst), .start(start), .cfg_is_read(cfg_is_read),
    .cfg_total(cfg_total), .cfg_first_dly(cfg_first_dly),
    .cfg_gap_min(cfg_gap_min), .cfg_gap_max(cfg_gap_max), .cfg_seed(cfg_seed),
    .cfg_wait_done(cfg_wait_done), .cfg_base(cfg_base), .cfg_region(cfg_region),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_read(req_is_read),
    .req_addr(req_addr), .req_len(req_len), .burst_done(burst_done), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int draw_gap(input int gmin, input int gmax);
    int g;
    g = gmin;
    if (gmax >= gmin) g = gmin + int'(lfsr_m) % (gmax - gmin + 1);
    lfsr_m = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
    return g;
  endfunction

  task automatic apply_cfg(input int tot, input int dly, input int gmin, input int gmax,
                           input int seed, input bit wt, input bit dir,
                           input int base, input int region);
    cfg_total = 16'(tot); cfg_first_dly = 16'(dly);
    cfg_gap_min = 16'(gmin); cfg_gap_max = 16'(gmax);
    cfg_seed = 16'(seed); cfg_wait_done = wt; cfg_is_read = dir;
    cfg_base = AW'(base); cfg_region = AW'(region);
  endtask

  task automatic run_seq(input int tot, input int dly, input int gmin, input int gmax,
                         input int seed, input bit wt, input bit dir,
                         input int base, input int region, input int rdy_pct,
                         input int restart_at);
    int cyc, exp_at, issued, etot, done_at, bd_at, act_hs, rs_at;
    bit waiting, exp_v, rdy, bd, prev_v, prev_r, prev_s, prev_dir;
    logic [AW-1:0] off, prev_addr;
    string lbl;
    rs_at = restart_at;
    @(negedge clk);
    apply_cfg(tot, dly, gmin, gmax, seed, wt, dir, base, region);
    start = 1'b1; req_ready = 1'b0; burst_done = 1'b0;
    etot = (tot < 2) ? 2 : tot;
    exp_at = dly + 1; issued = 0; waiting = 0; done_at = BIG; bd_at = -1;
    lfsr_m = (seed == 0) ? 16'd1 : 16'(seed); off = '0; act_hs = 0;
    prev_v = 0; prev_r = 0; prev_s = 1; prev_addr = '0; prev_dir = 0;
    cyc = 0;
    while (cyc < 4000) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      // R13: scramble configuration pins while the sequence runs
      apply_cfg($urandom_range(0, 9), $urandom_range(0, 9), $urandom_range(0, 9),
                $urandom_range(0, 9), $urandom, $urandom_range(0, 1), $urandom_range(0, 1),
                $urandom, $urandom);
      exp_v = !waiting && issued < etot && cyc >= exp_at;
      lbl = (issued == 0) ? "R2" : (wt ? "R9" : "R3/R4/R10");
      check(req_valid == exp_v, lbl, "req_valid", req_valid, exp_v);
      check(done == (cyc >= done_at), "R11", "done", done, cyc >= done_at);
      if (req_valid && exp_v) begin
        check(req_addr == AW'(base) + off, "R8", "req_addr", req_addr, AW'(base) + off);
        check(req_is_read == dir, "R7", "req_is_read", req_is_read, dir);
        check(req_len == 6'(BB / DB), "R7", "req_len", req_len, BB / DB);
      end
      if (prev_v && !prev_r && !prev_s) begin
        check(req_valid == 1'b1, "R5", "valid held", req_valid, 1);
        check(req_addr == prev_addr && req_is_read == prev_dir, "R5", "fields held",
              req_addr, prev_addr);
      end
      prev_v = req_valid; prev_addr = req_addr; prev_dir = req_is_read; prev_s = 0;
      if (cyc == rs_at) begin
        // R12: restart mid-sequence with the same settings
        apply_cfg(tot, dly, gmin, gmax, seed, wt, dir, base, region);
        start = 1'b1; req_ready = 1'b0; burst_done = 1'b0;
        exp_at = dly + 1; issued = 0; waiting = 0; done_at = BIG; bd_at = -1;
        lfsr_m = (seed == 0) ? 16'd1 : 16'(seed); off = '0; act_hs = 0;
        prev_v = 0; prev_r = 0; prev_s = 1; rs_at = 0; cyc = 0;
        @(negedge clk);
        cyc = 1; start = 1'b0;
        check(done == 1'b0 && req_valid == (dly == 0), "R12", "after restart",
              {done, req_valid}, {1'b0, dly == 0});
        exp_v = (dly == 0);
        prev_v = req_valid; prev_addr = req_addr; prev_dir = req_is_read;
      end
      rdy = ($urandom_range(0, 99) < rdy_pct);
      if (wt) bd = (cyc == bd_at);
      else    bd = ($urandom_range(0, 3) == 0);
      req_ready = rdy; burst_done = bd; prev_r = rdy;
      if (req_valid && rdy) act_hs++;
      if (exp_v && rdy) begin
        issued++;
        off = ((off + BB) >= AW'(region)) ? '0 : off + BB;
        if (wt) begin
          waiting = 1; bd_at = cyc + 1 + $urandom_range(0, 5);
        end else if (issued == etot) done_at = cyc + 1;
        else exp_at = cyc + 1 + draw_gap(gmin, gmax);
      end else if (wt && bd && waiting) begin
        waiting = 0;
        if (issued == etot) done_at = cyc + 1;
        else exp_at = cyc + 1 + draw_gap(gmin, gmax);
      end
      if (cyc > done_at + 2) break;
    end
    @(negedge clk);
    req_ready = 1'b0; burst_done = 1'b0;
    check(act_hs == etot, "R6", "accepted count", act_hs, etot);
    check(done == 1'b1, "R11", "done holds", done, 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1: idle after reset, no start yet
    check(req_valid == 1'b0 && done == 1'b0, "R1", "reset state", {req_valid, done}, 0);
    // back-to-back writes, no delay, zero gap
    run_seq(4, 0, 0, 0, 1, 0, 0, 32'h1000, 32'h10000, 100, 0);
    // total below 2, completion pacing, fixed gap
    run_seq(1, 5, 3, 3, 7, 1, 1, 32'h2000, 32'h10000, 100, 0);
    // max below min gives min
    run_seq(5, 2, 4, 1, 99, 0, 1, 32'h0, 32'h10000, 70, 0);
    // wrap in a two-burst region
    run_seq(5, 1, 1, 2, 0, 0, 0, 32'h8000, 512, 60, 0);
    // restart mid-run
    run_seq(6, 3, 2, 5, 123, 0, 1, 32'h400, 32'h1000, 50, 9);
    run_seq(4, 0, 0, 3, 555, 1, 0, 32'h100, 32'h800, 40, 6);
    for (int i = 0; i < 8; i++) begin
      run_seq($urandom_range(0, 12), $urandom_range(0, 20), $urandom_range(0, 6),
              $urandom_range(0, 12), $urandom_range(0, 65535), $urandom_range(0, 1),
              $urandom_range(0, 1), $urandom_range(0, 255) * 16,
              BB * $urandom_range(1, 6), $urandom_range(20, 100), 0);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule